// File: doc/BRIEF.md
# Timer Capture Channel with Selectable Trigger Path

This block pairs a 16-bit up/down counter with one capture channel. When the chosen edge of an external trigger arrives, the channel copies the running count into a capture register. It also sets a capture-done flag and, if enabled, raises a DMA request. Software or a DMA engine then reads the captured halfword from the `cap_val` output, which maps to one fixed source.

A mode input chooses how the trigger reaches the counter's clock domain. In clocked mode the trigger level goes through a two-flop synchronizer and an edge detector, so the captured count is always a settled value of the counter register. In edge-latch mode the trigger itself clocks a pending flop, one for rising edges and one for falling edges. That pending bit is then synchronized into the clock domain, and it is cleared by a handshake once the capture is taken. This lets a pulse narrower than one clock period, which no clock edge ever samples, still produce a capture.

Top module: `tmr_capture_chan`

## Requirements
- R1: After reset the counter is 0. While `cnt_run` is 1 it adds 1 per clock (`cnt_down`=0) or subtracts 1 (`cnt_down`=1), wrapping between 0xFFFF and 0x0000. While `cnt_run` is 0 it holds its value.
- R2: With `sync_mode`=1, a qualifying trigger edge is captured at the third rising clock edge after the trigger edge. The first edge that can sample the new level counts as the first. The captured value is the counter value held between the second and third of those edges.
- R3: With `sync_mode`=0, the capture has the same latency and value rule as R2. A high pulse shorter than one clock period that contains no rising clock edge still produces a capture. With `sync_mode`=1 the same pulse produces none.
- R4: `trig_sel` picks the qualifying edges. Bit 0 enables rising edges and bit 1 enables falling edges, so 0 = none, 1 = rising, 2 = falling and 3 = both. A non-qualifying edge leaves `cap_done` and `cap_val` unchanged.
- R5: Every capture sets `cap_done`. A one-cycle `flag_clr` pulse clears `cap_done` and `cap_ovf`.
- R6: A capture that occurs while `cap_done` is already 1 sets `cap_ovf`, and `cap_val` takes the newer count.
- R7: `irq` is 1 exactly when `cap_done` and `irq_en` are both 1.
- R8: A capture with `dma_en`=1 sets `dma_req` in the same cycle as `cap_done`. With `dma_en`=0 it leaves `dma_req` at 0. `dma_req` stays 1 until a `dma_ack` cycle, which clears both `dma_req` and `cap_done` one clock later.
- R9: After reset `cap_val`, `cap_done`, `cap_ovf`, `dma_req` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_run | input | 1 | Counter enable |
| cnt_down | input | 1 | Count direction, 1 = down |
| cap_trig | input | 1 | Capture trigger, may be asynchronous |
| sync_mode | input | 1 | 1 = clocked trigger path, 0 = edge-latch path |
| trig_sel | input | 2 | Edge select: bit 0 rising, bit 1 falling |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-1 clear of done and overwrite flags |
| dma_en | input | 1 | DMA request enable |
| dma_ack | input | 1 | DMA acknowledge pulse |
| cnt_val | output | 16 | Current counter value |
| cap_val | output | 16 | Capture register |
| cap_done | output | 1 | Capture-done flag |
| cap_ovf | output | 1 | Overwrite flag |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | DMA request |

## Verification
Counter changes appear at the edge that follows a sample. Each trigger is placed 1 ns after a rising edge, and the bench records the count at the falling edge between the second and third clock edges that follow. It then checks the capture register and flags at the falling edge after the third edge. It also confirms that the flags had not yet moved one cycle earlier. Acknowledge and clear strobes are driven for one full cycle from a falling edge, and their effect is checked at the next falling edge. Missed or non-qualifying triggers are checked again eight cycles later, so that a late capture would also be caught.

// File: rtl/tmr_capture_pkg.sv
`timescale 1ns/1ps
package tmr_capture_pkg;
    localparam int unsigned SEL_RISE_BIT = 0;
    localparam int unsigned SEL_FALL_BIT = 1;

    typedef struct packed {
        logic done;
        logic ovf;
        logic dreq;
    } cap_flags_t;
endpackage

// File: rtl/tmr_updown_counter.sv
`timescale 1ns/1ps
module tmr_updown_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         down,
    output logic [W-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (down) st_d.cnt = st_q.cnt - 1'b1;
            else      st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R1: step up, step down, hold
    a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        run && !down |=> cnt_o == W'($past(cnt_o) + 1'b1));
    a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        run && down |=> cnt_o == W'($past(cnt_o) - 1'b1));
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_sync_trig.sv
`timescale 1ns/1ps
module tmr_sync_trig #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic en_rise,
    input  logic en_fall,
    output logic ev_o
);
    typedef struct packed {
        logic [SYNC_N:0] sh;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic lvl_now, lvl_prev;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SYNC_N-1:0], trig};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_now  = st_q.sh[SYNC_N-1];
    assign lvl_prev = st_q.sh[SYNC_N];
    assign ev_o     = (en_rise && lvl_now && !lvl_prev) ||
                      (en_fall && !lvl_now && lvl_prev);

    // R2: an event can only follow a level change through the synchronizer
    a_r2_event_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o |-> lvl_now != lvl_prev);
endmodule

// File: rtl/tmr_async_trig.sv
`timescale 1ns/1ps
module tmr_async_trig #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic arm_rise,
    input  logic arm_fall,
    output logic ev_o
);
    typedef struct packed {
        logic [SYNC_N-1:0] sh;
        logic              ack;
    } async_state_t;

    async_state_t st_d, st_q;
    logic pend_rise, pend_fall, pend_clr, seen;

    assign pend_clr = !rst_n || st_q.ack;

    always_ff @(posedge trig or posedge pend_clr) begin
        if (pend_clr)      pend_rise <= 1'b0;
        else if (arm_rise) pend_rise <= 1'b1;
    end

    always_ff @(negedge trig or posedge pend_clr) begin
        if (pend_clr)      pend_fall <= 1'b0;
        else if (arm_fall) pend_fall <= 1'b1;
    end

    assign seen = st_q.sh[SYNC_N-1];

    always_comb begin
        st_d     = st_q;
        st_d.sh  = {st_q.sh[SYNC_N-2:0], pend_rise | pend_fall};
        st_d.ack = seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_o = seen && !st_q.ack;

    // R3: one pending edge yields a single event, never two in a row
    a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o |=> !ev_o);
endmodule

// File: rtl/tmr_capture_chan.sv
`timescale 1ns/1ps
module tmr_capture_chan #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_run,
    input  logic             cnt_down,
    input  logic             cap_trig,
    input  logic             sync_mode,
    input  logic [1:0]       trig_sel,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             dma_en,
    input  logic             dma_ack,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_done,
    output logic             cap_ovf,
    output logic             irq,
    output logic             dma_req
);
    import tmr_capture_pkg::*;

    typedef struct packed {
        cap_flags_t       flg;
        logic [CNT_W-1:0] cap;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic ev_sync, ev_async, cap_ev;
    logic use_rise, use_fall;

    assign use_rise = trig_sel[SEL_RISE_BIT];
    assign use_fall = trig_sel[SEL_FALL_BIT];

    tmr_updown_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cnt_run),
        .down  (cnt_down),
        .cnt_o (cnt_val)
    );

    tmr_sync_trig #(.SYNC_N(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (cap_trig),
        .en_rise (sync_mode && use_rise),
        .en_fall (sync_mode && use_fall),
        .ev_o    (ev_sync)
    );

    tmr_async_trig #(.SYNC_N(SYNC_N)) u_async (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (cap_trig),
        .arm_rise (!sync_mode && use_rise),
        .arm_fall (!sync_mode && use_fall),
        .ev_o     (ev_async)
    );

    assign cap_ev = ev_sync || ev_async;

    always_comb begin
        st_d = st_q;
        if (flag_clr) begin
            st_d.flg.done = 1'b0;
            st_d.flg.ovf  = 1'b0;
        end
        if (dma_ack) begin
            st_d.flg.done = 1'b0;
            st_d.flg.dreq = 1'b0;
        end
        if (cap_ev) begin
            st_d.cap      = cnt_val;
            st_d.flg.done = 1'b1;
            if (st_q.flg.done) st_d.flg.ovf = 1'b1;
            if (dma_en)        st_d.flg.dreq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_val  = st_q.cap;
    assign cap_done = st_q.flg.done;
    assign cap_ovf  = st_q.flg.ovf;
    assign dma_req  = st_q.flg.dreq;
    assign irq      = st_q.flg.done && irq_en;

    // R8: request held until acknowledged, ack clears request and done
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_ack |=> dma_req);
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack && !cap_ev |=> !dma_req && !cap_done);
    // R6: overwrite flag only rises on top of a pending capture
    a_r6_ovf_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_ovf) |-> $past(cap_done));
    // R5: a capture always leaves the done flag set
    a_r5_capture_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> cap_done);
endmodule

// File: tb/tb_tmr_capture_chan.sv
`timescale 1ns/1ps
module tb_tmr_capture_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_run = 1'b0, cnt_down = 1'b0, cap_trig = 1'b0;
    logic        sync_mode = 1'b1, irq_en = 1'b0, flag_clr = 1'b0;
    logic        dma_en = 1'b0, dma_ack = 1'b0;
    logic [1:0]  trig_sel = 2'd0;
    logic [15:0] cnt_val, cap_val;
    logic        cap_done, cap_ovf, irq, dma_req;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tmr_capture_chan dut (
        .clk(clk), .rst_n(rst_n), .cnt_run(cnt_run), .cnt_down(cnt_down),
        .cap_trig(cap_trig), .sync_mode(sync_mode), .trig_sel(trig_sel),
        .irq_en(irq_en), .flag_clr(flag_clr), .dma_en(dma_en), .dma_ack(dma_ack),
        .cnt_val(cnt_val), .cap_val(cap_val), .cap_done(cap_done),
        .cap_ovf(cap_ovf), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    // narrow=1: 1 ns high pulse with no rising clock edge inside
    task automatic fire(input bit narrow, input logic lvl, input bit exp_cap,
                        input bit do_clr, input string req);
        logic [15:0] expv;
        logic        done_before;
        if (do_clr) pulse_clr();
        done_before = cap_done;
        @(posedge clk);
        #1;
        if (narrow) begin
            cap_trig = 1'b1;
            #1 cap_trig = 1'b0;
        end else begin
            cap_trig = lvl;
        end
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        expv = cnt_val;
        if (do_clr) chk(cap_done == 1'b0, {req, " early"}, cap_done, 0);
        @(posedge clk);
        @(negedge clk);
        if (exp_cap) begin
            chk(cap_done == 1'b1, {req, " done"}, cap_done, 1);
            chk(cap_val == expv, {req, " value"}, cap_val, expv);
        end else begin
            chk(cap_done == done_before, {req, " no capture"}, cap_done, done_before);
        end
        repeat (8) @(negedge clk);
        if (!exp_cap)
            chk(cap_done == done_before, {req, " still none"}, cap_done, done_before);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] prev;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(cnt_val == 0, "R9 cnt", cnt_val, 0);
        chk(cap_val == 0, "R9 cap", cap_val, 0);
        chk({cap_done, cap_ovf, dma_req, irq} == 0, "R9 flags",
            {cap_done, cap_ovf, dma_req, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cnt_val == 0, "R1 hold", cnt_val, 0);
        cnt_run = 1'b1; cnt_down = 1'b1;
        @(negedge clk);
        chk(cnt_val == 16'hFFFF, "R1 down wrap", cnt_val, 16'hFFFF);
        cnt_down = 1'b0;
        @(negedge clk);
        chk(cnt_val == 16'h0000, "R1 up wrap", cnt_val, 0);
        for (int i = 0; i < 5; i++) begin
            prev = cnt_val;
            @(negedge clk);
            chk(cnt_val == prev + 16'd1, "R1 up", cnt_val, prev + 16'd1);
        end
        cnt_down = 1'b1;
        for (int i = 0; i < 3; i++) begin
            prev = cnt_val;
            @(negedge clk);
            chk(cnt_val == prev - 16'd1, "R1 down", cnt_val, prev - 16'd1);
        end
        cnt_run = 1'b0;
        prev = cnt_val;
        @(negedge clk);
        chk(cnt_val == prev, "R1 stopped", cnt_val, prev);
        cnt_run = 1'b1; cnt_down = 1'b0;

        // R2 clocked capture while counting down
        cnt_down = 1'b1; sync_mode = 1'b1; trig_sel = 2'd1;
        fire(0, 1'b1, 1, 1, "R2 sync rise");
        fire(0, 1'b0, 0, 1, "R2 sync fall ignored");
        cnt_down = 1'b0;

        // R4 sweep of mode x edge select x edge kind
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                sync_mode = m[0];
                trig_sel = s[1:0];
                fire(0, 1'b1, s[0], 1, "R4 rise");
                fire(0, 1'b0, s[1], 1, "R4 fall");
            end
        end

        // R3 narrow pulse
        @(negedge clk); sync_mode = 1'b0; trig_sel = 2'd1;
        fire(1, 1'b0, 1, 1, "R3 async narrow rise");
        @(negedge clk); trig_sel = 2'd2;
        fire(1, 1'b0, 1, 1, "R3 async narrow fall");
        @(negedge clk); sync_mode = 1'b1; trig_sel = 2'd3;
        fire(1, 1'b0, 0, 1, "R3 sync narrow missed");

        // R7 interrupt gating, R6 overwrite, R5 clear
        @(negedge clk); sync_mode = 1'b1; trig_sel = 2'd3; irq_en = 1'b0;
        fire(0, 1'b1, 1, 1, "R6 first");
        chk(irq == 1'b0, "R7 masked", irq, 0);
        irq_en = 1'b1;
        #0.5;
        chk(irq == 1'b1, "R7 enabled", irq, 1);
        chk(cap_ovf == 1'b0, "R6 no ovf yet", cap_ovf, 0);
        fire(0, 1'b0, 1, 0, "R6 second");
        chk(cap_ovf == 1'b1, "R6 ovf", cap_ovf, 1);
        pulse_clr();
        chk({cap_done, cap_ovf} == 2'b00, "R5 clear", {cap_done, cap_ovf}, 0);
        chk(irq == 1'b0, "R7 after clear", irq, 0);
        irq_en = 1'b0;

        // R8 DMA request handshake
        dma_en = 1'b0;
        fire(0, 1'b1, 1, 1, "R8 no dma");
        chk(dma_req == 1'b0, "R8 disabled", dma_req, 0);
        dma_en = 1'b1;
        fire(0, 1'b0, 1, 1, "R8 dma capture");
        chk(dma_req == 1'b1, "R8 req held", dma_req, 1);
        @(negedge clk) dma_ack = 1'b1;
        @(negedge clk) dma_ack = 1'b0;
        chk(dma_req == 1'b0, "R8 ack req", dma_req, 0);
        chk(cap_done == 1'b0, "R8 ack done", cap_done, 0);
        dma_en = 1'b0;

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule